// File: doc/BRIEF.md
# Transceiver Port Sleep and Power-Down Controller

This block decides the power state of one Ethernet transceiver port. It picks an effective sleep enable, either from a board pin or, when the port is under management control, from a register bit. It measures how long the line has been silent, using a prescaled tick counter and one of four timeout settings. When the line has been quiet for the whole selected window, the block puts the port to sleep. Line energy wakes it into a link-check state. A link-up returns it to normal operation. If no link comes up within the same window, the port goes back to sleep.

A soft power-down bit overrides the sleep logic and shuts the port at once. Fiber operation disables sleep entirely. The block asserts a management-available flag from the end of reset onward, including during sleep and power-down, so that the serial management engine beside it keeps answering. The prescaler period and the timeout table (a base count plus a per-code step) are parameters. Silicon settings span roughly one to three seconds, while a bench can use a short time base.

Top module: `phy_pwr_sleep_ctl`

## Requirements
- R1: The effective sleep enable equals `reg_sleep_en_i` when `managed_i` is 1, and `sleep_pin_i` when `managed_i` is 0.
- R2: With eligibility held (effective enable 1, `fiber_i` 0, `reg_pdown_i` 0) and `energy_i` low, `pwr_state_o` becomes SLEEP on clock edge L*TICK_DIV+1 after reset release or after the last edge at which the count was restarted.
- R3: The tick limit is L = TMO_BASE + code*TMO_STEP for `tmo_sel_i` = code, so code 3 gives the longest window and code 0 the shortest.
- R4: In ACTIVE, a clock edge that samples `energy_i` high restarts the idle count.
- R5: In SLEEP, an edge that samples `energy_i` high moves the state to LINK_CHECK.
- R6: In LINK_CHECK without `link_up_i`, the state returns to SLEEP on edge L*TICK_DIV+1 after LINK_CHECK was entered.
- R7: In LINK_CHECK, an edge that samples `link_up_i` high moves the state to ACTIVE.
- R8: On the edge after the effective enable is 0 or `fiber_i` is 1, the state is ACTIVE, from any state, and sleep is never entered while this condition lasts.
- R9: While `reg_pdown_i` is 1, `port_en_o` is 0, `low_power_o` is 1 and `pwr_state_o` is 3. After release the idle count starts fresh, as in R2.
- R10: `mgmt_avail_o` is 0 during reset and 1 from the first edge after reset release onward, including in SLEEP and power-down.
- R11: State codes are ACTIVE=0, SLEEP=1, LINK_CHECK=2, POWER_DOWN=3. `port_en_o` is 0 and `low_power_o` is 1 exactly in SLEEP or power-down.
- R12: `energy_i` has no effect during LINK_CHECK. The link-check window times out as in R6 even with energy held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_pin_i | input | 1 | Board-level sleep enable |
| managed_i | input | 1 | Port under management control; the register enable takes over |
| reg_sleep_en_i | input | 1 | Register sleep enable used in managed mode |
| reg_pdown_i | input | 1 | Soft power-down control bit |
| tmo_sel_i | input | 2 | Idle / link-check timeout select |
| fiber_i | input | 1 | Port runs on fiber media; sleep disabled |
| energy_i | input | 1 | Line energy detected |
| link_up_i | input | 1 | Link established |
| port_en_o | output | 1 | Network port enabled |
| low_power_o | output | 1 | Port in a low-power state |
| mgmt_avail_o | output | 1 | Management access available |
| pwr_state_o | output | 2 | Reported power state code |

## Verification
The hardest situation to reach is the link-check timeout while line energy stays high. It needs a full idle window to reach SLEEP, then a wake, then a second full window in which energy must not restart the count. The bench uses a four-clock tick and small limits, so every timeout code can be swept through sleep, wake and fall-back within a few hundred cycles. It counts edges up to each state change and compares them with L*TICK_DIV+1 computed from the code.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

   typedef enum logic [1:0] {
      PS_ACTIVE  = 2'd0,
      PS_SLEEP   = 2'd1,
      PS_LINKCHK = 2'd2,
      PS_PDOWN   = 2'd3
   } pwr_state_e;

endpackage

// File: rtl/phy_pwr_en_sel.sv
module phy_pwr_en_sel #(
   parameter bit ALLOW_REG_OVERRIDE = 1'b1
) (
   input  logic pin_en_i,
   input  logic managed_i,
   input  logic reg_en_i,
   output logic en_o
);

   generate
      if (ALLOW_REG_OVERRIDE) begin : g_override
         // managed mode hands control to the register bit
         assign en_o = managed_i ? reg_en_i : pin_en_i;
      end else begin : g_pin_only
         logic unused_sel;
         assign unused_sel = managed_i ^ reg_en_i;
         assign en_o = pin_en_i;
      end
   endgenerate

endmodule

// File: rtl/phy_pwr_tick.sv
module phy_pwr_tick #(
   parameter int unsigned TICK_DIV = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("phy_pwr_tick: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_every_cycle
         logic unused_in;
         assign unused_in = clr_i ^ rst_n;
         assign tick_o = 1'b1;
      end else begin : g_divider
         localparam int unsigned CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         assign tick_o = (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (tick_o) cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
         end

         assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/phy_pwr_timer.sv
module phy_pwr_timer #(
   parameter int unsigned TICK_DIV  = 125000,
   parameter int unsigned TMO_BASE  = 1000,
   parameter int unsigned TMO_STEP  = 680
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [1:0] code_i,
   output logic       expired_o
);

   localparam int unsigned LIMIT_MAX = TMO_BASE + 3 * TMO_STEP;
   localparam int unsigned W         = $clog2(LIMIT_MAX + 1);
   localparam logic [W-1:0] BASE_W   = W'(TMO_BASE);
   localparam logic [W-1:0] STEP_W   = W'(TMO_STEP);
   localparam logic [W-1:0] MAX_W    = W'(LIMIT_MAX);

   generate
      if (TMO_BASE < 1) begin : g_bad_base
         $error("phy_pwr_timer: TMO_BASE must be at least 1");
      end
      if (TMO_STEP < 1) begin : g_bad_step
         $error("phy_pwr_timer: TMO_STEP must be at least 1");
      end
   endgenerate

   logic         tick;
   logic [W-1:0] ticks_q;
   logic [W-1:0] limit;

   phy_pwr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .tick_o (tick)
   );

   // ascending table: base plus one step per code value
   assign limit     = BASE_W + STEP_W * {{(W-2){1'b0}}, code_i};
   assign expired_o = (ticks_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ticks_q <= '0;
      else if (clr_i)                  ticks_q <= '0;
      else if (tick && ticks_q < MAX_W) ticks_q <= ticks_q + 1'b1;
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ticks_q <= MAX_W);

   assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ticks_q == '0));

endmodule

// File: rtl/phy_pwr_fsm.sv
module phy_pwr_fsm
   import phy_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       eligible_i,
   input  logic       energy_i,
   input  logic       link_up_i,
   input  logic       expired_i,
   output pwr_state_e state_o,
   output logic       timer_clr_o
);

   pwr_state_e state_q, state_d;

   always_comb begin
      state_d     = state_q;
      timer_clr_o = 1'b0;
      if (!eligible_i) begin
         state_d     = PS_ACTIVE;
         timer_clr_o = 1'b1;
      end else begin
         unique case (state_q)
            PS_ACTIVE: begin
               if (energy_i) begin
                  timer_clr_o = 1'b1;
               end else if (expired_i) begin
                  state_d     = PS_SLEEP;
                  timer_clr_o = 1'b1;
               end
            end
            PS_SLEEP: begin
               timer_clr_o = 1'b1;
               if (energy_i) state_d = PS_LINKCHK;
            end
            PS_LINKCHK: begin
               // line energy is irrelevant here; only link or timeout matter
               if (link_up_i) begin
                  state_d     = PS_ACTIVE;
                  timer_clr_o = 1'b1;
               end else if (expired_i) begin
                  state_d     = PS_SLEEP;
                  timer_clr_o = 1'b1;
               end
            end
            default: begin
               state_d     = PS_ACTIVE;
               timer_clr_o = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_ACTIVE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   assert_ineligible_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !eligible_i |=> (state_q == PS_ACTIVE));

   assert_sleep_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SLEEP && $past(state_q) == PS_ACTIVE) |-> $past(expired_i && !energy_i));

   assert_wake_to_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SLEEP && eligible_i && energy_i) |=> (state_q == PS_LINKCHK));

   assert_link_to_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_LINKCHK && eligible_i && link_up_i) |=> (state_q == PS_ACTIVE));

endmodule

// File: rtl/phy_pwr_sleep_ctl.sv
module phy_pwr_sleep_ctl
   import phy_pwr_pkg::*;
#(
   parameter int unsigned TICK_DIV           = 125000,
   parameter int unsigned TMO_BASE           = 1000,
   parameter int unsigned TMO_STEP           = 680,
   parameter bit          ALLOW_REG_OVERRIDE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_pin_i,
   input  logic       managed_i,
   input  logic       reg_sleep_en_i,
   input  logic       reg_pdown_i,
   input  logic [1:0] tmo_sel_i,
   input  logic       fiber_i,
   input  logic       energy_i,
   input  logic       link_up_i,
   output logic       port_en_o,
   output logic       low_power_o,
   output logic       mgmt_avail_o,
   output logic [1:0] pwr_state_o
);

   logic       sleep_en;
   logic       eligible;
   logic       expired;
   logic       timer_clr;
   pwr_state_e fsm_state;
   logic       mgmt_q;

   phy_pwr_en_sel #(.ALLOW_REG_OVERRIDE(ALLOW_REG_OVERRIDE)) u_en_sel (
      .pin_en_i  (sleep_pin_i),
      .managed_i (managed_i),
      .reg_en_i  (reg_sleep_en_i),
      .en_o      (sleep_en)
   );

   assign eligible = sleep_en & ~fiber_i & ~reg_pdown_i;

   phy_pwr_timer #(
      .TICK_DIV (TICK_DIV),
      .TMO_BASE (TMO_BASE),
      .TMO_STEP (TMO_STEP)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (timer_clr),
      .code_i    (tmo_sel_i),
      .expired_o (expired)
   );

   phy_pwr_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .eligible_i  (eligible),
      .energy_i    (energy_i),
      .link_up_i   (link_up_i),
      .expired_i   (expired),
      .state_o     (fsm_state),
      .timer_clr_o (timer_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mgmt_q <= 1'b0;
      else        mgmt_q <= 1'b1;
   end

   assign mgmt_avail_o = mgmt_q;
   assign pwr_state_o  = reg_pdown_i ? PS_PDOWN : fsm_state;
   assign port_en_o    = ~reg_pdown_i & (fsm_state != PS_SLEEP);
   assign low_power_o  = reg_pdown_i | (fsm_state == PS_SLEEP);

   assert_mgmt_in_low_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power_o && $past(rst_n)) |-> mgmt_avail_o);

   assert_pdown_shuts_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_pdown_i |-> (!port_en_o && pwr_state_o == 2'd3));

   assert_port_vs_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
      port_en_o != low_power_o);

endmodule

// File: tb/phy_pwr_sleep_ctl_bench.sv
`timescale 1ns/1ps
module phy_pwr_sleep_ctl_bench;

   localparam int DIV  = 4;
   localparam int BASE = 2;
   localparam int STEP = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_pin = 1'b1;
   logic       managed = 1'b0;
   logic       reg_en = 1'b0;
   logic       pdown = 1'b0;
   logic [1:0] tsel = 2'd3;
   logic       fiber = 1'b0;
   logic       energy = 1'b0;
   logic       link = 1'b0;
   logic       port_en, low_pwr, mgmt;
   logic [1:0] st;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   phy_pwr_sleep_ctl #(
      .TICK_DIV (DIV),
      .TMO_BASE (BASE),
      .TMO_STEP (STEP)
   ) u_phy_pwr_sleep_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .sleep_pin_i    (sleep_pin),
      .managed_i      (managed),
      .reg_sleep_en_i (reg_en),
      .reg_pdown_i    (pdown),
      .tmo_sel_i      (tsel),
      .fiber_i        (fiber),
      .energy_i       (energy),
      .link_up_i      (link),
      .port_en_o      (port_en),
      .low_power_o    (low_pwr),
      .mgmt_avail_o   (mgmt),
      .pwr_state_o    (st)
   );

   function automatic int exp_cyc(input int code);
      return (BASE + code * STEP) * DIV + 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_until(input logic [1:0] tgt, input int lim, output int n);
      n = 0;
      do begin
         @(posedge clk); #1;
         n++;
      end while (st !== tgt && n < lim);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(st == 2'd0, "R11 reset state", st, 0);
      chk(mgmt == 1'b0, "R10 mgmt in reset", mgmt, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      int n;
      // sweep every timeout code through sleep, wake, fallback, link
      for (int c = 0; c < 4; c++) begin
         managed = 1'b0; sleep_pin = 1'b1; tsel = 2'(c);
         energy = 1'b0; link = 1'b0; fiber = 1'b0; pdown = 1'b0;
         do_reset();
         run_until(2'd1, 200, n);
         chk(n == exp_cyc(c), "R2 R3 idle to sleep cycles", n, exp_cyc(c));
         chk(mgmt == 1'b1, "R10 mgmt in sleep", mgmt, 1);
         chk(port_en == 1'b0 && low_pwr == 1'b1, "R11 sleep outputs", {port_en, low_pwr}, 1);
         @(negedge clk); energy = 1'b1;
         @(posedge clk); #1;
         chk(st == 2'd2, "R5 wake to link check", st, 2);
         chk(port_en == 1'b1 && low_pwr == 1'b0, "R11 link check outputs", {port_en, low_pwr}, 2);
         @(negedge clk); energy = 1'b0;
         run_until(2'd1, 200, n);
         chk(n == exp_cyc(c), "R6 link check timeout", n, exp_cyc(c));
         @(negedge clk); energy = 1'b1;
         @(posedge clk); #1;
         @(negedge clk); energy = 1'b0; link = 1'b1;
         @(posedge clk); #1;
         chk(st == 2'd0, "R7 link up to active", st, 0);
         @(negedge clk); link = 1'b0;
      end

      // R12: energy held high through link check is ignored
      tsel = 2'd1;
      do_reset();
      run_until(2'd1, 200, n);
      @(negedge clk); energy = 1'b1;
      @(posedge clk); #1;
      run_until(2'd1, 200, n);
      chk(n == exp_cyc(1), "R12 energy ignored in link check", n, exp_cyc(1));
      @(negedge clk); energy = 1'b0;
      @(posedge clk); #1;
      chk(st == 2'd1, "R12 stays asleep", st, 1);

      // R4: energy pulse in active restarts the count
      tsel = 2'd2;
      do_reset();
      repeat (5) @(negedge clk);
      energy = 1'b1;
      @(negedge clk); energy = 1'b0;
      run_until(2'd1, 200, n);
      chk(n == exp_cyc(2), "R4 restart on energy", n, exp_cyc(2));

      // R1: effective enable selection
      tsel = 2'd0;
      managed = 1'b1; reg_en = 1'b0; sleep_pin = 1'b1;
      do_reset();
      repeat (3 * exp_cyc(0)) @(posedge clk);
      #1 chk(st == 2'd0, "R1 register override disables", st, 0);
      managed = 1'b1; reg_en = 1'b1; sleep_pin = 1'b0;
      do_reset();
      run_until(2'd1, 200, n);
      chk(n == exp_cyc(0), "R1 register override enables", n, exp_cyc(0));
      managed = 1'b0; reg_en = 1'b1; sleep_pin = 1'b0;
      do_reset();
      repeat (3 * exp_cyc(0)) @(posedge clk);
      #1 chk(st == 2'd0, "R1 pin used when unmanaged", st, 0);

      // R8: drop enable from sleep, fiber from link check, fiber in active
      sleep_pin = 1'b1;
      do_reset();
      run_until(2'd1, 200, n);
      @(negedge clk); sleep_pin = 1'b0;
      @(posedge clk); #1;
      chk(st == 2'd0, "R8 enable cleared in sleep", st, 0);
      @(negedge clk); sleep_pin = 1'b1;
      run_until(2'd1, 200, n);
      @(negedge clk); energy = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); energy = 1'b0; fiber = 1'b1;
      @(posedge clk); #1;
      chk(st == 2'd0, "R8 fiber in link check", st, 0);
      repeat (3 * exp_cyc(0)) @(posedge clk);
      #1 chk(st == 2'd0, "R8 fiber blocks sleep", st, 0);
      @(negedge clk); fiber = 1'b0;

      // R9: soft power-down overrides, then fresh count
      run_until(2'd1, 200, n);
      @(negedge clk); pdown = 1'b1;
      #1;
      chk(st == 2'd3 && port_en == 1'b0 && low_pwr == 1'b1, "R9 power-down outputs", st, 3);
      repeat (3) @(posedge clk);
      #1 chk(mgmt == 1'b1, "R10 mgmt in power-down", mgmt, 1);
      @(negedge clk); pdown = 1'b0;
      #1 chk(st == 2'd0 && port_en == 1'b1, "R9 released to active", st, 0);
      run_until(2'd1, 200, n);
      chk(n == exp_cyc(0), "R9 fresh count after release", n, exp_cyc(0));

      done = 1'b1;
   end

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired");
         end
         wait (done);
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule